// File: doc/BRIEF.md
# Privilege Check and Exception Sequencer

This block sits beside a simple processor's instruction loop and owns the program counter, the processor mode bit and a saved-PC register. It enforces a two-level protection scheme. Addresses below a fixed boundary (default 100) belong to the operating system. While the processor runs in user mode, any touch of that region is refused. This covers instruction fetch and every operand access, including the pointer target of an indirect load. An attempt to rewrite the mode bit from user mode is also refused.

Each cycle in which `step` is high, the processor presents the attributes of the instruction at the current PC: valid operand addresses, a mode-write request, a trap request with its service number, a return-from-exception request and an optional branch target. The block then does one of two things. It either lets the instruction execute and advances the PC, or it takes exactly one hard-wired vector. When it takes a vector, it saves the faulting PC, enters system mode, and latches a cause code together with, for traps, the service number. System code reads these and leaves through a return request.

Top module: `priv_seq`

## Requirements
- R1: After reset the PC is 0, the mode is system (mode bit 0), the saved PC is 0, the cause code is 0 and the service number is 0.
- R2: When `step` is low, nothing changes. When `step` is high and no vector is taken, the PC becomes `branch_pc` if `branch` is high, and otherwise PC+4 modulo 2^AW.
- R3: In user mode (mode bit 1), a step whose PC is below 100 takes the memory vector. The saved PC becomes the PC, the PC becomes 60, the mode becomes 0, the cause becomes 1, and `exec_ok` is low.
- R4: In user mode, a step with any valid operand address below 100 takes the memory vector 60 with cause 1. Operand slots whose valid bit is 0 are not checked. Address 100 itself is allowed.
- R5: In user mode, a step with `mode_wr` high takes the mode vector. The saved PC becomes the PC, the PC becomes 64, the mode becomes 0 and the cause becomes 2. In system mode, `mode_wr` loads the mode from `mode_wdata`.
- R6: A step with `trap` high takes the trap vector 68 from either mode. It saves the PC, sets the mode to 0, sets the cause to 3 and latches `trap_id` as the service number.
- R7: When several conditions hold for one step, only one vector is taken. The priority, highest first, is: fetch violation, trap, mode-write violation, operand violation.
- R8: In system mode, a step with `rfe` high and no trap loads the PC from the saved PC and sets the mode to 1. In user mode, `rfe` has no effect, and the step advances as in R2.
- R9: The cause code and the service number change only when a vector is taken. A memory or mode vector leaves the service number unchanged.
- R10: In system mode, no address is checked: fetches and operands below 100 execute normally.
- R11: `vec_taken` is high exactly in the cycles where a step takes a vector, and `exec_ok` is high exactly in the cycles where a step is allowed to execute. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction at the current PC completes this cycle |
| opnd_valid | input | NOPND | Per-slot flag marking an operand address in use |
| opnd_addr | input | NOPND*AW | Operand addresses, slot i at bits [i*AW +: AW] |
| mode_wr | input | 1 | Instruction writes the mode bit |
| mode_wdata | input | 1 | Value written to the mode bit |
| trap | input | 1 | Instruction is a trap |
| trap_id | input | TW | Service number carried by the trap |
| rfe | input | 1 | Return-from-exception request |
| branch | input | 1 | Instruction redirects the PC |
| branch_pc | input | AW | Branch target |
| pc | output | AW | Program counter |
| mode | output | 1 | 0 = system, 1 = user |
| saved_pc | output | AW | PC of the last instruction that took a vector |
| cause | output | 2 | 0 none, 1 memory, 2 mode, 3 trap |
| service_id | output | TW | Service number of the last trap |
| exec_ok | output | 1 | Current step may execute |
| vec_taken | output | 1 | Current step takes a vector |

## Verification
Directed sequences cover each kind of violation at and just below the boundary: operand address 99 against 100, and a PC just under the boundary against one above it. Each is tried with the offending operand in a valid slot and in an invalid slot, which separates a real check from one that ignores the valid bits. Stacked conditions on one step (trap with fetch fault, mode write with operand fault) expose a wrong priority order. Returns from both modes show whether `rfe` is gated by privilege. A long pseudo-random phase then mixes all inputs and modes so that the cycle reference model catches stray interactions among the saved PC, the cause and the service-number latches.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_MEM  = 2'd1,
        CAUSE_MODE = 2'd2,
        CAUSE_TRAP = 2'd3
    } cause_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_ADVANCE,
        ACT_FETCH_FAULT,
        ACT_TRAP,
        ACT_MODE_FAULT,
        ACT_OPND_FAULT,
        ACT_RETURN
    } act_e;

    localparam logic MODE_SYS = 1'b0;
    localparam logic MODE_USR = 1'b1;

endpackage

// File: rtl/priv_addr_check.sv
module priv_addr_check #(
    parameter int AW       = 8,
    parameter int NOPND    = 3,
    parameter int OS_LIMIT = 100
) (
    input  logic                 user,
    input  logic [AW-1:0]        pc,
    input  logic [NOPND-1:0]     opnd_valid,
    input  logic [NOPND*AW-1:0]  opnd_addr,
    output logic                 fetch_viol,
    output logic                 opnd_viol
);
    localparam logic [AW-1:0] LIMIT_A = AW'(OS_LIMIT);

    logic [NOPND-1:0] slot_hit;

    // One comparator per operand slot
    for (genvar i = 0; i < NOPND; i++) begin : g_slot
        logic [AW-1:0] a;
        assign a           = opnd_addr[i*AW +: AW];
        assign slot_hit[i] = opnd_valid[i] && (a < LIMIT_A);
    end

    assign fetch_viol = user && (pc < LIMIT_A);
    assign opnd_viol  = user && (|slot_hit);

    // R4: an unused slot never raises a violation on its own
    always_comb begin
        if (opnd_valid == '0) begin
            assert (!opnd_viol) else $error("p_invalid_slot_r4");
        end
    end
endmodule

// File: rtl/priv_arbiter.sv
module priv_arbiter
    import priv_pkg::*;
(
    input  logic step,
    input  logic user,
    input  logic fetch_viol,
    input  logic trap,
    input  logic mode_wr,
    input  logic opnd_viol,
    input  logic rfe,
    output act_e act
);
    // Fixed priority: fetch fault, trap, mode fault, operand fault, return
    always_comb begin
        if (!step)                 act = ACT_IDLE;
        else if (fetch_viol)       act = ACT_FETCH_FAULT;
        else if (trap)             act = ACT_TRAP;
        else if (user && mode_wr)  act = ACT_MODE_FAULT;
        else if (opnd_viol)        act = ACT_OPND_FAULT;
        else if (!user && rfe)     act = ACT_RETURN;
        else                       act = ACT_ADVANCE;
    end

    // R7: a trap never wins over a fetch fault
    always_comb begin
        if (step && fetch_viol) begin
            assert (act == ACT_FETCH_FAULT) else $error("p_fetch_first_r7");
        end
    end
endmodule

// File: rtl/priv_seq.sv
module priv_seq
    import priv_pkg::*;
#(
    parameter int AW       = 8,
    parameter int NOPND    = 3,
    parameter int TW       = 4,
    parameter int OS_LIMIT = 100,
    parameter int VEC_MEM  = 60,
    parameter int VEC_MODE = 64,
    parameter int VEC_TRAP = 68,
    parameter int ILEN     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic [NOPND-1:0]     opnd_valid,
    input  logic [NOPND*AW-1:0]  opnd_addr,
    input  logic                 mode_wr,
    input  logic                 mode_wdata,
    input  logic                 trap,
    input  logic [TW-1:0]        trap_id,
    input  logic                 rfe,
    input  logic                 branch,
    input  logic [AW-1:0]        branch_pc,
    output logic [AW-1:0]        pc,
    output logic                 mode,
    output logic [AW-1:0]        saved_pc,
    output logic [1:0]           cause,
    output logic [TW-1:0]        service_id,
    output logic                 exec_ok,
    output logic                 vec_taken
);
    localparam logic [AW-1:0] LIMIT_A = AW'(OS_LIMIT);
    localparam logic [AW-1:0] VMEM_A  = AW'(VEC_MEM);
    localparam logic [AW-1:0] VMODE_A = AW'(VEC_MODE);
    localparam logic [AW-1:0] VTRAP_A = AW'(VEC_TRAP);
    localparam logic [AW-1:0] ILEN_A  = AW'(ILEN);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          mode;
        logic [AW-1:0] epc;
        cause_e        cause;
        logic [TW-1:0] svc;
    } state_t;

    state_t s_q, s_d;
    logic   fetch_viol, opnd_viol;
    act_e   act;
    logic   take_vec;

    priv_addr_check #(.AW(AW), .NOPND(NOPND), .OS_LIMIT(OS_LIMIT)) u_chk (
        .user       (s_q.mode == MODE_USR),
        .pc         (s_q.pc),
        .opnd_valid (opnd_valid),
        .opnd_addr  (opnd_addr),
        .fetch_viol (fetch_viol),
        .opnd_viol  (opnd_viol)
    );

    priv_arbiter u_arb (
        .step       (step),
        .user       (s_q.mode == MODE_USR),
        .fetch_viol (fetch_viol),
        .trap       (trap),
        .mode_wr    (mode_wr),
        .opnd_viol  (opnd_viol),
        .rfe        (rfe),
        .act        (act)
    );

    assign take_vec = (act == ACT_FETCH_FAULT) || (act == ACT_TRAP) ||
                      (act == ACT_MODE_FAULT)  || (act == ACT_OPND_FAULT);

    always_comb begin
        s_d = s_q;
        if (take_vec) begin
            s_d.epc  = s_q.pc;
            s_d.mode = MODE_SYS;
        end
        unique case (act)
            ACT_FETCH_FAULT,
            ACT_OPND_FAULT: begin
                s_d.pc    = VMEM_A;
                s_d.cause = CAUSE_MEM;
            end
            ACT_MODE_FAULT: begin
                s_d.pc    = VMODE_A;
                s_d.cause = CAUSE_MODE;
            end
            ACT_TRAP: begin
                s_d.pc    = VTRAP_A;
                s_d.cause = CAUSE_TRAP;
                s_d.svc   = trap_id;
            end
            ACT_RETURN: begin
                s_d.pc   = s_q.epc;
                s_d.mode = MODE_USR;
            end
            ACT_ADVANCE: begin
                if (mode_wr && s_q.mode == MODE_SYS) s_d.mode = mode_wdata;
                s_d.pc = branch ? branch_pc : s_q.pc + ILEN_A;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.pc    <= '0;
            s_q.mode  <= MODE_SYS;
            s_q.epc   <= '0;
            s_q.cause <= CAUSE_NONE;
            s_q.svc   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pc         = s_q.pc;
    assign mode       = s_q.mode;
    assign saved_pc   = s_q.epc;
    assign cause      = s_q.cause;
    assign service_id = s_q.svc;
    assign vec_taken  = take_vec;
    assign exec_ok    = step && !take_vec;

    // R3: user fetch below the boundary lands on the memory vector in system mode
    p_fetch_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode && pc < LIMIT_A) |=>
        (pc == VMEM_A && saved_pc == $past(pc) && !mode && cause == 2'd1));

    // R5: the mode bit leaves user mode only through a vector
    p_user_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !vec_taken) |=> mode);

    // R6: a trap that is not pre-empted by a fetch fault reaches the trap vector
    p_trap_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && trap && !(mode && pc < LIMIT_A)) |=>
        (pc == VTRAP_A && cause == 2'd3 && service_id == $past(trap_id) && !mode));

    // R8: a system-mode return without a trap restores the saved PC in user mode
    p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && rfe && !mode && !trap) |=> (mode && pc == $past(saved_pc)));

    // R9: cause and service number only move when a vector is taken
    p_cause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_taken |=> ($stable(cause) && $stable(service_id) && $stable(saved_pc)));

    // R11: execute and vector never coincide, and both require a step
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_ok && vec_taken) && ((exec_ok || vec_taken) == step));

endmodule

// File: tb/tb_priv_seq.sv
module tb_priv_seq;
    localparam int PERIOD = 10;
    localparam int AW = 8;
    localparam int NOPND = 3;
    localparam int TW = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic step = 0;
    logic [NOPND-1:0] opnd_valid = '0;
    logic [NOPND*AW-1:0] opnd_addr = '0;
    logic mode_wr = 0, mode_wdata = 0, trap = 0, rfe = 0, branch = 0;
    logic [TW-1:0] trap_id = '0;
    logic [AW-1:0] branch_pc = '0;
    logic [AW-1:0] pc, saved_pc;
    logic mode, exec_ok, vec_taken;
    logic [1:0] cause;
    logic [TW-1:0] service_id;

    int vectors = 0, errors = 0;
    int m_pc = 0, m_mode = 0, m_epc = 0, m_cause = 0, m_svc = 0;

    always #(PERIOD/2) clk = ~clk;

    priv_seq dut (
        .clk(clk), .rst_n(rst_n), .step(step), .opnd_valid(opnd_valid),
        .opnd_addr(opnd_addr), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .trap(trap), .trap_id(trap_id), .rfe(rfe), .branch(branch),
        .branch_pc(branch_pc), .pc(pc), .mode(mode), .saved_pc(saved_pc),
        .cause(cause), .service_id(service_id), .exec_ok(exec_ok),
        .vec_taken(vec_taken)
    );

    task automatic check_state(string tag);
        vectors++;
        if (int'(pc) != m_pc || int'(mode) != m_mode || int'(saved_pc) != m_epc ||
            int'(cause) != m_cause || int'(service_id) != m_svc) begin
            errors++;
            $display("FAIL %s state: pc=%0d mode=%0d spc=%0d cause=%0d svc=%0d expected pc=%0d mode=%0d spc=%0d cause=%0d svc=%0d",
                     tag, pc, mode, saved_pc, cause, service_id,
                     m_pc, m_mode, m_epc, m_cause, m_svc);
        end
    endtask

    // Inputs are already driven (posedge+1); compare strobes, clock, compare state
    task automatic tick(string tag);
        bit ov, vec;
        int n_pc, n_mode, n_epc, n_cause, n_svc;
        #2;
        ov = 0;
        for (int i = 0; i < NOPND; i++)
            if (opnd_valid[i] && int'(opnd_addr[i*AW +: AW]) < 100) ov = 1;
        n_pc = m_pc; n_mode = m_mode; n_epc = m_epc; n_cause = m_cause; n_svc = m_svc;
        vec = 0;
        if (step) begin
            if (m_mode == 1 && m_pc < 100) begin vec = 1; n_pc = 60; n_cause = 1; end
            else if (trap) begin vec = 1; n_pc = 68; n_cause = 3; n_svc = int'(trap_id); end
            else if (m_mode == 1 && mode_wr) begin vec = 1; n_pc = 64; n_cause = 2; end
            else if (m_mode == 1 && ov) begin vec = 1; n_pc = 60; n_cause = 1; end
            else if (m_mode == 0 && rfe) begin n_pc = m_epc; n_mode = 1; end
            else begin
                if (m_mode == 0 && mode_wr) n_mode = int'(mode_wdata);
                n_pc = branch ? int'(branch_pc) : (m_pc + 4) % 256;
            end
            if (vec) begin n_epc = m_pc; n_mode = 0; end
        end
        vectors++;
        if (vec_taken !== vec || exec_ok !== (step && !vec)) begin
            errors++;
            $display("FAIL %s strobes: vec=%0b exec=%0b expected vec=%0b exec=%0b",
                     tag, vec_taken, exec_ok, vec, step && !vec);
        end
        @(posedge clk);
        #1;
        m_pc = n_pc; m_mode = n_mode; m_epc = n_epc; m_cause = n_cause; m_svc = n_svc;
        check_state(tag);
        step = 0; opnd_valid = '0; opnd_addr = '0; mode_wr = 0; mode_wdata = 0;
        trap = 0; rfe = 0; branch = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check_state("R1");
        tick("R2");                                  // idle: nothing moves
        // R10: system mode touches low memory freely
        step = 1; opnd_valid = 3'b111; opnd_addr = {8'd1, 8'd50, 8'd99}; tick("R10");
        // R5 system write of mode bit plus branch to 120
        step = 1; mode_wr = 1; mode_wdata = 1; branch = 1; branch_pc = 8'd120; tick("R5");
        // R4 boundary: 100 allowed, 99 refused, invalid slot ignored
        step = 1; opnd_valid = 3'b001; opnd_addr = {8'd0, 8'd0, 8'd100}; tick("R4");
        step = 1; opnd_valid = 3'b011; opnd_addr = {8'd5, 8'd200, 8'd130}; tick("R4");
        step = 1; opnd_valid = 3'b100; opnd_addr = {8'd99, 8'd0, 8'd0}; tick("R4");
        step = 1; rfe = 1; tick("R8");               // back to user at saved PC
        // R5 user mode write
        step = 1; mode_wr = 1; mode_wdata = 0; tick("R5");
        tick("R9");
        step = 1; tick("R9");                        // system advance, cause held
        step = 1; rfe = 1; tick("R8");
        // R6 trap from user mode
        step = 1; trap = 1; trap_id = 4'd9; tick("R6");
        // R6 trap from system mode
        step = 1; trap = 1; trap_id = 4'd5; tick("R6");
        step = 1; branch = 1; branch_pc = 8'd200; tick("R2");
        step = 1; rfe = 1; tick("R8");               // returns to 68 in user
        // R3 + R7: fetch fault beats trap, service number kept
        step = 1; trap = 1; trap_id = 4'd2; tick("R7");
        step = 1; mode_wr = 1; mode_wdata = 1; branch = 1; branch_pc = 8'd160; tick("R5");
        // R7: trap beats mode write and operand fault
        step = 1; trap = 1; trap_id = 4'd12; mode_wr = 1; opnd_valid = 3'b001; opnd_addr = 24'd3; tick("R7");
        step = 1; rfe = 1; tick("R8");
        // R7: mode write beats operand fault
        step = 1; mode_wr = 1; opnd_valid = 3'b010; opnd_addr = {8'd0, 8'd7, 8'd0}; tick("R7");
        step = 1; rfe = 1; tick("R8");
        // R8: rfe in user is ignored
        step = 1; rfe = 1; tick("R8");
        // R3: user branch into low memory then fetch fault
        step = 1; branch = 1; branch_pc = 8'd96; tick("R2");
        step = 1; tick("R3");
        // Mixed pseudo-random phase
        for (int k = 0; k < 3000; k++) begin
            step       = ($urandom_range(0, 7) != 0);
            opnd_valid = NOPND'($urandom);
            opnd_addr  = NOPND*AW'({$urandom, $urandom});
            mode_wr    = ($urandom_range(0, 9) == 0);
            mode_wdata = 1'($urandom);
            trap       = ($urandom_range(0, 15) == 0);
            trap_id    = TW'($urandom);
            rfe        = ($urandom_range(0, 5) == 0);
            branch     = ($urandom_range(0, 3) == 0);
            branch_pc  = AW'($urandom);
            tick("R11");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule